// File: doc/BRIEF.md
# Horizontal Scan-Line Timing Generator

This block produces the horizontal timing of one raster scan line. A pixel-clock enable moves a column counter across the visible area and then across the blanking interval. From the column the block derives a display-enable level, a horizontal sync pulse placed inside the blanking interval, and a strobe that marks the final column of each line. The counter wraps at the end of the line.

Software programs four timing fields through a small write port. Each field counts in groups of eight pixels and holds one less than the group count. The fields are the visible width, the blanking length, the distance from the first blanking pixel to the sync leading edge, and the sync pulse length. Writes land in a pending copy, and the pending copy becomes the live copy only when a line ends. No line can therefore mix old and new timing.

The pending values are checked continuously against the legal ranges. Any violation sets a sticky error flag, and the flag holds the sync output low until reset.

Top module: `hline_timer`

## Requirements
- R1: Reset clears the column to 0. The column then rises by one on each clock edge where `pix_en` is high, and holds on any edge where it is low.
- R2: A line lasts (W+1)·8 + (B+1)·8 enabled cycles. W is the live width field and B is the live blanking field. After the last column the counter returns to 0.
- R3: `de` is high exactly when the column is below (W+1)·8.
- R4: When `cfg_err` is low, `hsync` is high exactly for columns from A+(S+1)·8 up to, but not including, A+(S+P+2)·8. A is the active width in pixels, S is the start field and P is the pulse field.
- R5: `eol` is high exactly when `pix_en` is high and the column is the last column of the line.
- R6: A write with `wr_en` high stores the low bits of `wr_data` into a pending field. `wr_sel` picks the field: 0 is the width (7 bits), 1 is blanking (5 bits), 2 is sync start (5 bits) and 3 is pulse length (4 bits). Pending fields become live on the edge that wraps the column to 0. The line in progress keeps its old timing.
- R7: After reset all four fields, pending and live, are W=7, B=3, S=0 and P=1. This gives 64 visible columns, a 96-column line, and sync on columns 72 to 87.
- R8: `cfg_err` rises one clock after the pending fields break any of these rules: W<3; B<3; B < S+P+1; or `passive_mode` high with W even (visible width not a multiple of 16). Once set, it stays high until reset.
- R9: While `cfg_err` is high, `hsync` stays low.
- R10: Right after reset, with `pix_en` low, the outputs are: column 0, `de` high, `hsync` low, `eol` low and `cfg_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Advances the column by one pixel |
| wr_en | input | 1 | Writes one pending timing field |
| wr_sel | input | 2 | Field select for a write |
| wr_data | input | 7 | Write data, low bits used |
| passive_mode | input | 1 | Requires the visible width to be a multiple of 16 pixels |
| de | output | 1 | Display enable |
| col | output | 11 | Current pixel column |
| hsync | output | 1 | Horizontal sync pulse |
| eol | output | 1 | Last-column strobe |
| cfg_err | output | 1 | Sticky configuration error |

## Verification
The random part draws legal configurations with short widths and varied blanking, start and pulse lengths. It writes them mid-line in an order that never leaves the pending set illegal, under a gappy pixel enable. This separates counting on enable from counting on every clock, and shows whether sync edges are placed relative to the blanking start or to the line end. Directed sequences cover the cases the random part avoids:
- a width change mid-line, which shows whether the new value leaks into the current line;
- a sync pulse ending exactly on the last column;
- one violation per rule, each next to a legal value at the same boundary, which shows whether the comparisons use the right bound;
- a violation later repaired, which shows whether the flag is sticky.

// File: rtl/hline_pkg.sv
package hline_pkg;

    // Field widths of the timing registers (in 8-pixel groups, minus one)
    localparam int unsigned HW_W      = 7;
    localparam int unsigned BL_W      = 5;
    localparam int unsigned ST_W      = 5;
    localparam int unsigned PW_W      = 4;
    localparam int unsigned GRAN_LOG2 = 3;
    localparam int unsigned DATA_W    = HW_W;

    // Column counter must hold the longest possible line
    localparam int unsigned MAX_LINE  = ((2 ** HW_W) + (2 ** BL_W)) * (2 ** GRAN_LOG2);
    localparam int unsigned COL_W     = $clog2(MAX_LINE);

    typedef struct packed {
        logic [HW_W-1:0] act;
        logic [BL_W-1:0] blank;
        logic [ST_W-1:0] sstart;
        logic [PW_W-1:0] swidth;
    } hcfg_t;

    typedef enum logic [1:0] {
        SEL_ACT   = 2'd0,
        SEL_BLANK = 2'd1,
        SEL_START = 2'd2,
        SEL_WIDTH = 2'd3
    } hsel_e;

    localparam hcfg_t HCFG_RESET = '{act: 7'd7, blank: 5'd3, sstart: 5'd0, swidth: 4'd1};

endpackage

// File: rtl/hline_shadow.sv
// Pending/live copies of the timing fields and the sticky range checker.
module hline_shadow
    import hline_pkg::*;
#(
    parameter int unsigned MIN_UNITS = 3,
    parameter hcfg_t       RESET_CFG = HCFG_RESET
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              passive,
    input  logic              load,
    output hcfg_t             live_cfg,
    output logic              cfg_err
);

    localparam int unsigned NEED_W = BL_W + 2;

    typedef struct packed {
        hcfg_t pend;
        hcfg_t live;
        logic  err;
    } shadow_t;

    shadow_t           s_d, s_q;
    logic [NEED_W-1:0] need_units;
    logic              rule_min, rule_fit, rule_pass;

    always_comb begin
        // blanking must cover the start delay plus the pulse
        need_units = NEED_W'(s_q.pend.sstart) + NEED_W'(s_q.pend.swidth) + NEED_W'(1);
        rule_min   = (s_q.pend.act < HW_W'(MIN_UNITS)) || (s_q.pend.blank < BL_W'(MIN_UNITS));
        rule_fit   = NEED_W'(s_q.pend.blank) < need_units;
        rule_pass  = passive && !s_q.pend.act[0];

        s_d     = s_q;
        s_d.err = s_q.err | rule_min | rule_fit | rule_pass;
        if (load) begin
            s_d.live = s_q.pend;
        end
        if (wr_en) begin
            case (hsel_e'(wr_sel))
                SEL_ACT:   s_d.pend.act    = wr_data[HW_W-1:0];
                SEL_BLANK: s_d.pend.blank  = wr_data[BL_W-1:0];
                SEL_START: s_d.pend.sstart = wr_data[ST_W-1:0];
                SEL_WIDTH: s_d.pend.swidth = wr_data[PW_W-1:0];
                default:   s_d.pend        = s_q.pend;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{pend: RESET_CFG, live: RESET_CFG, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign live_cfg = s_q.live;
    assign cfg_err  = s_q.err;

endmodule

// File: rtl/hline_col.sv
// Pixel column counter; wraps after the last column of the live line.
module hline_col
    import hline_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_en,
    input  hcfg_t            live_cfg,
    output logic [COL_W-1:0] col,
    output logic             at_last
);

    localparam int unsigned LEN_W = COL_W + 1;

    logic [LEN_W-1:0] line_len;
    logic [COL_W-1:0] last_col;
    logic [COL_W-1:0] col_d, col_q;

    always_comb begin
        line_len = (LEN_W'(live_cfg.act) + 1'b1 + LEN_W'(live_cfg.blank) + 1'b1) << GRAN_LOG2;
        last_col = COL_W'(line_len - 1'b1);
        at_last  = (col_q == last_col);
        col_d    = col_q;
        if (pix_en) begin
            col_d = at_last ? '0 : col_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '0;
        end else begin
            col_q <= col_d;
        end
    end

    assign col = col_q;

endmodule

// File: rtl/hline_decode.sv
// Column-to-level decode for display enable and sync.
module hline_decode
    import hline_pkg::*;
(
    input  logic [COL_W-1:0] col,
    input  hcfg_t            live_cfg,
    input  logic             sync_block,
    output logic             de,
    output logic             hsync
);

    localparam int unsigned SUM_W = COL_W + 1;

    logic [SUM_W-1:0] act_px, sync_lo, sync_hi, col_x;

    always_comb begin
        col_x   = SUM_W'(col);
        act_px  = (SUM_W'(live_cfg.act) + 1'b1) << GRAN_LOG2;
        // leading edge counted from the first blanking pixel
        sync_lo = act_px + ((SUM_W'(live_cfg.sstart) + 1'b1) << GRAN_LOG2);
        sync_hi = sync_lo + ((SUM_W'(live_cfg.swidth) + 1'b1) << GRAN_LOG2);
        de      = col_x < act_px;
        hsync   = !sync_block && (col_x >= sync_lo) && (col_x < sync_hi);
    end

endmodule

// File: rtl/hline_timer.sv
module hline_timer
    import hline_pkg::*;
#(
    parameter int unsigned MIN_UNITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_en,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              passive_mode,
    output logic              de,
    output logic [COL_W-1:0]  col,
    output logic              hsync,
    output logic              eol,
    output logic              cfg_err
);

    hcfg_t live_cfg;
    logic  at_last;
    logic  line_wrap;

    assign line_wrap = pix_en & at_last;
    assign eol       = line_wrap;

    hline_shadow #(
        .MIN_UNITS (MIN_UNITS),
        .RESET_CFG (HCFG_RESET)
    ) i_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .passive  (passive_mode),
        .load     (line_wrap),
        .live_cfg (live_cfg),
        .cfg_err  (cfg_err)
    );

    hline_col i_col (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_en   (pix_en),
        .live_cfg (live_cfg),
        .col      (col),
        .at_last  (at_last)
    );

    hline_decode i_decode (
        .col        (col),
        .live_cfg   (live_cfg),
        .sync_block (cfg_err),
        .de         (de),
        .hsync      (hsync)
    );

endmodule

// File: rtl/hline_timer_chk.sv
module hline_timer_chk
    import hline_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             pix_en,
    input logic [COL_W-1:0] col,
    input logic             de,
    input logic             hsync,
    input logic             eol,
    input logic             cfg_err
);

    // R1
    col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> $stable(col));

    // R1
    col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && !eol) |=> (col == $past(col) + 1'b1));

    // R2
    col_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eol |=> (col == '0));

    // R4
    sync_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |-> !de);

    // R5
    eol_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eol |-> pix_en);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R9
    sync_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !hsync);

endmodule

bind hline_timer hline_timer_chk i_hline_timer_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pix_en  (pix_en),
    .col     (col),
    .de      (de),
    .hsync   (hsync),
    .eol     (eol),
    .cfg_err (cfg_err)
);

// File: tb/test_hline_timer.sv
module test_hline_timer;
    import hline_pkg::*;

    localparam int CLK_PERIOD      = 10;
    localparam int WATCHDOG_CYCLES = 190000;
    localparam int N_BATCH         = 30;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pix_en = 1'b0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_sel = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              passive_mode = 1'b0;
    logic              de, hsync, eol, cfg_err;
    logic [COL_W-1:0]  col;

    int n_tests = 0;
    int n_fail  = 0;
    bit pas_req = 1'b0;

    // model state: live and pending fields, column, error
    int m_w, m_b, m_s, m_p;
    int p_w, p_b, p_s, p_p;
    int m_col, line_cnt;
    bit m_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    hline_timer i_hline_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .pix_en       (pix_en),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .passive_mode (passive_mode),
        .de           (de),
        .col          (col),
        .hsync        (hsync),
        .eol          (eol),
        .cfg_err      (cfg_err)
    );

    function automatic int line_len(int w, int b);
        return (w + 1) * 8 + (b + 1) * 8;
    endfunction

    function automatic bit cfg_bad(int w, int b, int s, int p, bit pas);
        return (w < 3) || (b < 3) || (b < s + p + 1) || (pas && (w % 2 == 0));
    endfunction

    function automatic bit exp_sync(int c);
        int a, lo, hi;
        a  = (m_w + 1) * 8;
        lo = a + (m_s + 1) * 8;
        hi = lo + (m_p + 1) * 8;
        return !m_err && (c >= lo) && (c < hi);
    endfunction

    task automatic chk(string tag, int actual, int expected);
        n_tests++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    // one clock: drive at negedge, compare, then advance the model over the next posedge
    task automatic step(bit pe, bit we, int sel, int data);
        int last;
        @(negedge clk);
        pix_en       = pe;
        wr_en        = we;
        wr_sel       = 2'(sel);
        wr_data      = DATA_W'(data);
        passive_mode = pas_req;
        #1;
        last = line_len(m_w, m_b) - 1;
        chk("R1 col", int'(col), m_col);
        chk("R3 de", int'(de), int'(m_col < (m_w + 1) * 8));
        chk("R4 hsync", int'(hsync), int'(exp_sync(m_col)));
        chk("R5 eol", int'(eol), int'(pe && (m_col == last)));
        chk("R8 cfg_err", int'(cfg_err), int'(m_err));
        // R2: enabled cycles per line
        if (eol) begin
            chk("R2 line length", line_cnt + 1, last + 1);
            line_cnt = 0;
        end else if (pe) begin
            line_cnt++;
        end
        m_err = m_err || cfg_bad(p_w, p_b, p_s, p_p, pas_req);
        if (pe) begin
            if (m_col == last) begin
                m_col = 0;
                m_w = p_w; m_b = p_b; m_s = p_s; m_p = p_p;
            end else begin
                m_col++;
            end
        end
        if (we) begin
            case (sel)
                0: p_w = data & 127;
                1: p_b = data & 31;
                2: p_s = data & 31;
                default: p_p = data & 15;
            endcase
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pix_en = 1'b0; wr_en = 1'b0; passive_mode = pas_req;
        @(negedge clk);
        rst_n = 1'b1;
        m_w = 7; m_b = 3; m_s = 0; m_p = 1;
        p_w = 7; p_b = 3; p_s = 0; p_p = 1;
        m_col = 0; m_err = 1'b0; line_cnt = 0;
        #1;
        chk("R10 reset col", int'(col), 0);
        chk("R10 reset de", int'(de), 1);
        chk("R10 reset hsync", int'(hsync), 0);
        chk("R10 reset eol", int'(eol), 0);
        chk("R10 reset cfg_err", int'(cfg_err), 0);
    endtask

    task automatic run_to(int target);
        int guard = 0;
        step(1'b1, 1'b0, 0, 0);
        while (int'(col) != target && guard < 4000) begin
            step(1'b1, 1'b0, 0, 0);
            guard++;
        end
    endtask

    function automatic bit rnd_pe();
        return ($urandom % 5) != 0;
    endfunction

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(rnd_pe(), 1'b0, 0, 0);
    endtask

    task automatic run_lines(int k);
        int seen = 0;
        int guard = 0;
        while (seen < k && guard < 20000) begin
            step(rnd_pe(), 1'b0, 0, 0);
            if (eol) seen++;
            guard++;
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (R1): actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int cnt;
        void'($urandom(32'd4711));

        // R7: default line of 96 columns, sync at 72, visible 64
        pas_req = 1'b0;
        do_reset();
        for (int i = 0; i < 96; i++) step(1'b1, 1'b0, 0, 0);
        step(1'b0, 1'b0, 0, 0);
        chk("R7 default line wraps at 96", int'(col), 0);
        run_to(64);
        chk("R7 default visible width 64", int'(de), 0);
        run_to(72);
        chk("R7 default sync start 72", int'(hsync), 1);
        run_to(88);
        chk("R7 default sync end 88", int'(hsync), 0);

        // R6: width write mid-line waits for the next line
        do_reset();
        run_to(10);
        step(1'b1, 1'b1, 0, 3);
        run_to(40);
        chk("R6 current line keeps old width", int'(de), 1);
        run_to(0);
        run_to(40);
        chk("R6 next line uses new width", int'(de), 0);

        // R8: width at and below the minimum
        do_reset();
        step(1'b1, 1'b1, 0, 3);
        step(1'b1, 1'b0, 0, 0);
        step(1'b1, 1'b0, 0, 0);
        chk("R8 width 3 is legal", int'(cfg_err), 0);
        step(1'b1, 1'b1, 0, 2);
        step(1'b1, 1'b0, 0, 0);
        step(1'b1, 1'b0, 0, 0);
        chk("R8 width 2 flags error", int'(cfg_err), 1);
        // R9: no sync for a whole line once flagged
        cnt = 0;
        for (int i = 0; i < 200; i++) begin
            step(1'b1, 1'b0, 0, 0);
            if (hsync) cnt++;
        end
        chk("R9 sync held low under error", cnt, 0);

        // R8: passive mode needs odd width field
        pas_req = 1'b1;
        do_reset();
        idle(5);
        chk("R8 passive with width 7 legal", int'(cfg_err), 0);
        step(1'b1, 1'b1, 0, 8);
        step(1'b1, 1'b0, 0, 0);
        step(1'b1, 1'b0, 0, 0);
        chk("R8 passive with width 8 flags error", int'(cfg_err), 1);
        pas_req = 1'b0;

        // R8: pulse does not fit in blanking, then sticky after repair
        do_reset();
        step(1'b1, 1'b1, 3, 15);
        step(1'b1, 1'b0, 0, 0);
        step(1'b1, 1'b0, 0, 0);
        chk("R8 sync does not fit", int'(cfg_err), 1);
        step(1'b1, 1'b1, 3, 0);
        idle(10);
        chk("R8 error sticky after repair", int'(cfg_err), 1);

        // R4: pulse ending on the last column (B=3, S=1, P=1)
        do_reset();
        step(1'b1, 1'b1, 2, 1);
        step(1'b1, 1'b1, 3, 1);
        run_lines(2);
        run_to(95);
        chk("R4 sync reaches last column", int'(hsync), 1);
        chk("R8 exact fit is legal", int'(cfg_err), 0);

        // random legal configurations written mid-line
        do_reset();
        for (int b = 0; b < N_BATCH; b++) begin
            int nw, nb, ns, np, pmax;
            bit pas_batch;
            pas_batch = ($urandom % 4) == 0;
            nw = 3 + ($urandom % 18);
            if (pas_batch) nw = nw | 1;
            nb = 3 + ($urandom % 29);
            ns = $urandom % (nb - 1);
            pmax = nb - ns - 1;
            if (pmax > 15) pmax = 15;
            np = $urandom % (pmax + 1);
            if (!pas_batch || (nw % 2 == 0)) pas_req = 1'b0;
            // order keeps every intermediate pending set legal
            idle($urandom % 30); step(rnd_pe(), 1'b1, 2, 0);
            idle($urandom % 30); step(rnd_pe(), 1'b1, 3, 0);
            idle($urandom % 30); step(rnd_pe(), 1'b1, 1, nb);
            idle($urandom % 30); step(rnd_pe(), 1'b1, 0, nw);
            idle($urandom % 30); step(rnd_pe(), 1'b1, 2, ns);
            idle($urandom % 30); step(rnd_pe(), 1'b1, 3, np);
            if (pas_batch) pas_req = 1'b1;
            run_lines(3);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule